// File: doc/BRIEF.md
# Physical Region Pointer Walker

This block turns one transfer descriptor (a byte count plus two physical region pointers) into an ordered stream of DMA segments. Each segment is an address and a byte length. The first pointer may start part-way into a page, so the first segment only runs to the end of that page. What happens next depends on how many bytes are left. A remainder of at most one page is served directly by the second pointer. A larger remainder makes the second pointer the address of an in-memory table of 8-byte page pointers. The walker reads that table one entry at a time over a request/response memory port. When the final slot of a table page is reached and more than one page is still left, that slot names the next table page instead of a data page.

The page size comes from a configuration input, which is sampled when a descriptor is accepted. The walker moves no data. It ends every descriptor with a one-cycle completion pulse, which carries either a success code or an invalid-field code with the do-not-retry flag set. A malformed pointer stops the stream at once.

Top module: `prp_walker`

## Requirements
- R1: The page size is 4096 << `cfg_mps`, sampled when the descriptor is accepted. A table page holds page/8 entries. No segment is zero-length or longer than one page.
- R2: The first segment has address `cmd_ptr1` and length min(`cmd_len`, page − (`cmd_ptr1` mod page)).
- R3: A zero `cmd_ptr1` ends the descriptor with the error status and produces no segment.
- R4: If bytes remain after the first segment and `cmd_ptr2` is zero, the descriptor ends with the error status after the first segment.
- R5: If the remainder after the first segment is at most one page, one more segment follows, with address `cmd_ptr2` and the whole remainder as its length. A `cmd_ptr2` that is not page-aligned gives the error status instead of that segment.
- R6: If the remainder is more than one page, table slot k is read at `cmd_ptr2` + 8·k. The 64-bit response word is taken little-endian (the lowest-addressed byte is in bits 7:0). Each slot yields one segment of length min(remaining, page), in slot order.
- R7: When the slot being read is the last one of a table page and more than one page remains, its value becomes the new table base and slot numbering restarts at 0.
- R8: A data or chaining entry that is zero or not page-aligned ends the descriptor with the error status. No segment is produced for it or after it.
- R9: Completion is a single-cycle `done_valid` pulse. `done_status` is 16'h0000 on success. On error it is 16'h4002: code 8'h02 (invalid field) in bits 7:0 and do-not-retry in bit 14.
- R10: On success the segment lengths add up exactly to `cmd_len`, and they never exceed it.
- R11: `seg_addr`/`seg_len` hold steady while `seg_valid` is high and `seg_ready` is low. `rd_addr` holds steady while `rd_valid` is high and `rd_ready` is low. `cmd_ready` is low from acceptance until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mps | input | MPS_W | Page-size exponent above 4 KiB |
| cmd_valid | input | 1 | Descriptor offered |
| cmd_ready | output | 1 | Walker idle, descriptor accepted |
| cmd_ptr1 | input | ADDR_W | First region pointer |
| cmd_ptr2 | input | ADDR_W | Second region pointer or table pointer |
| cmd_len | input | LEN_W | Transfer length in bytes |
| rd_valid | output | 1 | Table entry read request |
| rd_ready | input | 1 | Read request taken |
| rd_addr | output | ADDR_W | Byte address of the 8-byte entry |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 64 | Entry value, little-endian |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Segment consumer ready |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes |
| done_valid | output | 1 | Completion pulse |
| done_status | output | 16 | Completion code |

## Verification
The checker assumes three things about the environment. `cmd_len` is non-zero. `cfg_mps` does not exceed MPS_MAX and stays unchanged while a descriptor is being walked. Exactly one read response follows each accepted read request. The page bound on `seg_len` and the running length total are only meaningful under these assumptions. The bench sets the page exponent only between descriptors, always uses positive lengths, and its memory model answers each request once, one cycle after accepting it. It also applies random back-pressure on the segment stream, so the hold checks are exercised under stalls.

// File: rtl/prp_walk_pkg.sv
package prp_walk_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FIRST,
      ST_DIRECT,
      ST_LIST,
      ST_DATA,
      ST_FINISH
   } walk_state_t;

   typedef enum logic [1:0] {
      FS_IDLE,
      FS_REQ,
      FS_WAIT
   } fetch_state_t;

   localparam logic [15:0] STS_OK        = 16'h0000;
   localparam logic [15:0] STS_BAD_FIELD = 16'h4002;

   localparam int PAGE_BASE_BITS = 12;
   localparam int ENTRY_BYTES_LG = 3;

endpackage

// File: rtl/prp_geom.sv
module prp_geom #(
   parameter int LEN_W   = 32,
   parameter int MPS_W   = 4,
   parameter int MPS_MAX = 4,
   parameter int IDX_W   = MPS_MAX + 9
) (
   input  logic [MPS_W-1:0] mps,
   output logic [LEN_W-1:0] page_bytes,
   output logic [LEN_W-1:0] page_mask,
   output logic [IDX_W-1:0] last_slot
);
   import prp_walk_pkg::*;

   localparam int LG_MAX_PAGE = PAGE_BASE_BITS + MPS_MAX;

   generate
      if (LEN_W <= LG_MAX_PAGE) begin : g_len_too_narrow
         $error("prp_geom: LEN_W must exceed the largest page exponent");
      end
      if (IDX_W != LG_MAX_PAGE - ENTRY_BYTES_LG) begin : g_idx_mismatch
         $error("prp_geom: IDX_W does not match the largest table page");
      end
   endgenerate

   assign page_bytes = LEN_W'(4096) << mps;
   assign page_mask  = page_bytes - LEN_W'(1);
   assign last_slot  = IDX_W'((page_bytes >> ENTRY_BYTES_LG) - LEN_W'(1));

endmodule

// File: rtl/prp_entry_fetch.sv
module prp_entry_fetch #(
   parameter int ADDR_W = 64,
   parameter int IDX_W  = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rsp_valid,
   input  logic [63:0]       rsp_data,
   output logic              ent_valid,
   output logic [ADDR_W-1:0] ent_addr,
   output logic              ent_nonzero
);
   import prp_walk_pkg::*;

   generate
      if (ADDR_W > 64 || ADDR_W < IDX_W + ENTRY_BYTES_LG) begin : g_bad_addr
         $error("prp_entry_fetch: ADDR_W out of range");
      end
   endgenerate

   fetch_state_t      fs;
   logic [ADDR_W-1:0] addr_q;
   logic [63:0]       ent_q;
   logic              ent_valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs          <= FS_IDLE;
         addr_q      <= '0;
         ent_q       <= '0;
         ent_valid_q <= 1'b0;
      end else begin
         ent_valid_q <= 1'b0;
         unique case (fs)
            FS_IDLE: begin
               if (go) begin
                  addr_q <= base + ADDR_W'({idx, 3'b000});
                  fs     <= FS_REQ;
               end
            end
            FS_REQ: begin
               if (rd_ready) begin
                  fs <= FS_WAIT;
               end
            end
            FS_WAIT: begin
               if (rsp_valid) begin
                  ent_q       <= rsp_data;
                  ent_valid_q <= 1'b1;
                  fs          <= FS_IDLE;
               end
            end
            default: fs <= FS_IDLE;
         endcase
      end
   end

   assign rd_valid    = (fs == FS_REQ);
   assign rd_addr     = addr_q;
   assign ent_valid   = ent_valid_q;
   assign ent_addr    = ent_q[ADDR_W-1:0];
   assign ent_nonzero = |ent_q;

endmodule

// File: rtl/prp_walker.sv
module prp_walker #(
   parameter int ADDR_W  = 64,
   parameter int LEN_W   = 32,
   parameter int MPS_W   = 4,
   parameter int MPS_MAX = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MPS_W-1:0]  cfg_mps,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [ADDR_W-1:0] cmd_ptr1,
   input  logic [ADDR_W-1:0] cmd_ptr2,
   input  logic [LEN_W-1:0]  cmd_len,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rsp_valid,
   input  logic [63:0]       rsp_data,
   output logic              seg_valid,
   input  logic              seg_ready,
   output logic [ADDR_W-1:0] seg_addr,
   output logic [LEN_W-1:0]  seg_len,
   output logic              done_valid,
   output logic [15:0]       done_status
);
   import prp_walk_pkg::*;

   localparam int IDX_W = MPS_MAX + PAGE_BASE_BITS - ENTRY_BYTES_LG;

   generate
      if (ADDR_W < LEN_W) begin : g_addr_narrow
         $error("prp_walker: ADDR_W must be at least LEN_W");
      end
      if (MPS_MAX >= (1 << MPS_W)) begin : g_mps_wide
         $error("prp_walker: MPS_MAX not encodable in MPS_W bits");
      end
   endgenerate

   walk_state_t       st;
   logic [MPS_W-1:0]  mps_q;
   logic [ADDR_W-1:0] ptr1_q;
   logic [ADDR_W-1:0] ptr2_q;
   logic [LEN_W-1:0]  rem_q;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;
   logic              err_q;
   logic              go_q;

   logic [LEN_W-1:0]  page_bytes;
   logic [LEN_W-1:0]  page_mask;
   logic [IDX_W-1:0]  last_slot;
   logic              ent_valid;
   logic [ADDR_W-1:0] ent_addr;
   logic              ent_nonzero;

   prp_geom #(
      .LEN_W   (LEN_W),
      .MPS_W   (MPS_W),
      .MPS_MAX (MPS_MAX),
      .IDX_W   (IDX_W)
   ) u_geom (
      .mps        (mps_q),
      .page_bytes (page_bytes),
      .page_mask  (page_mask),
      .last_slot  (last_slot)
   );

   prp_entry_fetch #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_fetch (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (go_q),
      .base        (base_q),
      .idx         (idx_q),
      .rd_valid    (rd_valid),
      .rd_ready    (rd_ready),
      .rd_addr     (rd_addr),
      .rsp_valid   (rsp_valid),
      .rsp_data    (rsp_data),
      .ent_valid   (ent_valid),
      .ent_addr    (ent_addr),
      .ent_nonzero (ent_nonzero)
   );

   logic [ADDR_W-1:0] mask_ext;
   logic [LEN_W-1:0]  first_off;
   logic [LEN_W-1:0]  first_room;
   logic [LEN_W-1:0]  first_len;
   logic [LEN_W-1:0]  page_len;
   logic [LEN_W-1:0]  rem_after;
   logic              ptr2_off;
   logic              ent_bad;
   logic              chain_slot;

   assign mask_ext   = ADDR_W'(page_mask);
   assign first_off  = ptr1_q[LEN_W-1:0] & page_mask;
   assign first_room = page_bytes - first_off;
   assign first_len  = (rem_q < first_room) ? rem_q : first_room;
   assign page_len   = (rem_q < page_bytes) ? rem_q : page_bytes;
   assign ptr2_off   = |(ptr2_q & mask_ext);
   assign ent_bad    = !ent_nonzero || (|(ent_addr & mask_ext));
   assign chain_slot = (idx_q == last_slot) && (rem_q > page_bytes);

   always_comb begin
      seg_valid = 1'b0;
      seg_addr  = '0;
      seg_len   = '0;
      unique case (st)
         ST_FIRST: begin
            seg_valid = 1'b1;
            seg_addr  = ptr1_q;
            seg_len   = first_len;
         end
         ST_DIRECT: begin
            seg_valid = 1'b1;
            seg_addr  = ptr2_q;
            seg_len   = rem_q;
         end
         ST_DATA: begin
            seg_valid = 1'b1;
            seg_addr  = ent_addr;
            seg_len   = page_len;
         end
         default: ;
      endcase
   end

   assign rem_after = rem_q - seg_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         mps_q  <= '0;
         ptr1_q <= '0;
         ptr2_q <= '0;
         rem_q  <= '0;
         base_q <= '0;
         idx_q  <= '0;
         err_q  <= 1'b0;
         go_q   <= 1'b0;
      end else begin
         go_q <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (cmd_valid) begin
                  mps_q  <= cfg_mps;
                  ptr1_q <= cmd_ptr1;
                  ptr2_q <= cmd_ptr2;
                  rem_q  <= cmd_len;
                  err_q  <= (cmd_ptr1 == '0);
                  st     <= (cmd_ptr1 == '0) ? ST_FINISH : ST_FIRST;
               end
            end
            ST_FIRST: begin
               if (seg_ready) begin
                  rem_q <= rem_after;
                  if (rem_after == '0) begin
                     st <= ST_FINISH;
                  end else if (ptr2_q == '0) begin
                     err_q <= 1'b1;
                     st    <= ST_FINISH;
                  end else if (rem_after <= page_bytes) begin
                     if (ptr2_off) begin
                        err_q <= 1'b1;
                        st    <= ST_FINISH;
                     end else begin
                        st <= ST_DIRECT;
                     end
                  end else begin
                     base_q <= ptr2_q;
                     idx_q  <= '0;
                     go_q   <= 1'b1;
                     st     <= ST_LIST;
                  end
               end
            end
            ST_DIRECT: begin
               if (seg_ready) begin
                  rem_q <= rem_after;
                  st    <= ST_FINISH;
               end
            end
            ST_LIST: begin
               if (ent_valid) begin
                  if (ent_bad) begin
                     err_q <= 1'b1;
                     st    <= ST_FINISH;
                  end else if (chain_slot) begin
                     base_q <= ent_addr;
                     idx_q  <= '0;
                     go_q   <= 1'b1;
                  end else begin
                     st <= ST_DATA;
                  end
               end
            end
            ST_DATA: begin
               if (seg_ready) begin
                  rem_q <= rem_after;
                  idx_q <= idx_q + IDX_W'(1);
                  if (rem_after == '0) begin
                     st <= ST_FINISH;
                  end else begin
                     go_q <= 1'b1;
                     st   <= ST_LIST;
                  end
               end
            end
            ST_FINISH: st <= ST_IDLE;
            default:   st <= ST_IDLE;
         endcase
      end
   end

   assign cmd_ready   = (st == ST_IDLE);
   assign done_valid  = (st == ST_FINISH);
   assign done_status = err_q ? STS_BAD_FIELD : STS_OK;

endmodule

// File: rtl/prp_walker_chk.sv
module prp_walker_chk #(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 32,
   parameter int MPS_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [MPS_W-1:0]  cfg_mps,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [LEN_W-1:0]  cmd_len,
   input logic              rd_valid,
   input logic              rd_ready,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              seg_valid,
   input logic              seg_ready,
   input logic [ADDR_W-1:0] seg_addr,
   input logic [LEN_W-1:0]  seg_len,
   input logic              done_valid,
   input logic [15:0]       done_status
);
   logic [LEN_W-1:0] chk_page;
   logic [LEN_W:0]   len_q;
   logic [LEN_W:0]   sum_q;

   assign chk_page = LEN_W'(4096) << cfg_mps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q <= '0;
         sum_q <= '0;
      end else if (cmd_valid && cmd_ready) begin
         len_q <= {1'b0, cmd_len};
         sum_q <= '0;
      end else if (seg_valid && seg_ready) begin
         sum_q <= sum_q + {1'b0, seg_len};
      end
   end

   assert_seg_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> (seg_len != '0) && (seg_len <= chk_page));

   assert_seg_nonzero_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> (seg_addr != '0));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   assert_done_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (done_status == 16'h0000) || (done_status == 16'h4002));

   assert_total_exact_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && (done_status == 16'h0000)) |-> (sum_q == len_q));

   assert_total_no_excess_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && seg_ready) |-> ((sum_q + {1'b0, seg_len}) <= len_q));

   assert_seg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_ready) |=> seg_valid && $stable(seg_addr) && $stable(seg_len));

   assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_addr));

   assert_busy_no_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid || rd_valid || done_valid) |-> !cmd_ready);

endmodule

bind prp_walker prp_walker_chk #(
   .ADDR_W (ADDR_W),
   .LEN_W  (LEN_W),
   .MPS_W  (MPS_W)
) u_prp_walker_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_mps     (cfg_mps),
   .cmd_valid   (cmd_valid),
   .cmd_ready   (cmd_ready),
   .cmd_len     (cmd_len),
   .rd_valid    (rd_valid),
   .rd_ready    (rd_ready),
   .rd_addr     (rd_addr),
   .seg_valid   (seg_valid),
   .seg_ready   (seg_ready),
   .seg_addr    (seg_addr),
   .seg_len     (seg_len),
   .done_valid  (done_valid),
   .done_status (done_status)
);

// File: tb/prp_walker_test.sv
module prp_walker_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_mps = '0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [63:0] cmd_ptr1 = '0;
   logic [63:0] cmd_ptr2 = '0;
   logic [31:0] cmd_len = '0;
   logic        rd_valid;
   logic        rd_ready = 1'b1;
   logic [63:0] rd_addr;
   logic        rsp_valid = 1'b0;
   logic [63:0] rsp_data = '0;
   logic        seg_valid;
   logic        seg_ready = 1'b1;
   logic [63:0] seg_addr;
   logic [31:0] seg_len;
   logic        done_valid;
   logic [15:0] done_status;

   always #10 clk = ~clk;

   prp_walker uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_mps     (cfg_mps),
      .cmd_valid   (cmd_valid),
      .cmd_ready   (cmd_ready),
      .cmd_ptr1    (cmd_ptr1),
      .cmd_ptr2    (cmd_ptr2),
      .cmd_len     (cmd_len),
      .rd_valid    (rd_valid),
      .rd_ready    (rd_ready),
      .rd_addr     (rd_addr),
      .rsp_valid   (rsp_valid),
      .rsp_data    (rsp_data),
      .seg_valid   (seg_valid),
      .seg_ready   (seg_ready),
      .seg_addr    (seg_addr),
      .seg_len     (seg_len),
      .done_valid  (done_valid),
      .done_status (done_status)
   );

   typedef struct packed {
      logic [63:0] a;
      logic [31:0] l;
   } seg_t;

   int          total = 0;
   int          bad = 0;
   seg_t        exp_q[$];
   logic [15:0] sts_q[$];
   logic [63:0] mem [logic [63:0]];
   logic [63:0] obs_sum = '0;
   bit          bp_en = 1'b0;
   string       tag = "reset";

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   function automatic logic [63:0] rd_mem(logic [63:0] a);
      return mem.exists(a) ? mem[a] : 64'h0;
   endfunction

   task automatic put_list(input logic [63:0] base, input int first, input int n,
                           input logic [63:0] d0, input logic [63:0] step);
      for (int i = 0; i < n; i++) begin
         mem[base + 64'(8 * (first + i))] = d0 + step * 64'(i);
      end
   endtask

   // Reference model built from R1..R9; returns the expected byte total
   function automatic logic [63:0] model(input int mps, input logic [63:0] p1,
                                         input logic [63:0] p2, input logic [31:0] len);
      logic [63:0] page, mask, rem, room, base, e, l, sum;
      int ents, i;
      seg_t s;
      page = 64'h1000 << mps;
      mask = page - 1;
      ents = int'(page / 8);
      rem  = 64'(len);
      sum  = 0;
      if (p1 == 0) begin
         sts_q.push_back(16'h4002);
         return 0;
      end
      room = page - (p1 & mask);
      l = (rem < room) ? rem : room;
      s.a = p1; s.l = l[31:0]; exp_q.push_back(s);
      sum += l; rem -= l;
      if (rem == 0) begin
         sts_q.push_back(16'h0000);
         return sum;
      end
      if (p2 == 0) begin
         sts_q.push_back(16'h4002);
         return sum;
      end
      if (rem <= page) begin
         if ((p2 & mask) != 0) begin
            sts_q.push_back(16'h4002);
            return sum;
         end
         s.a = p2; s.l = rem[31:0]; exp_q.push_back(s);
         sts_q.push_back(16'h0000);
         return sum + rem;
      end
      base = p2;
      i = 0;
      while (rem != 0) begin
         e = rd_mem(base + 64'(8 * i));
         if (e == 0 || (e & mask) != 0) begin
            sts_q.push_back(16'h4002);
            return sum;
         end
         if (i == ents - 1 && rem > page) begin
            base = e;
            i = 0;
         end else begin
            l = (rem < page) ? rem : page;
            s.a = e; s.l = l[31:0]; exp_q.push_back(s);
            sum += l; rem -= l;
            i++;
         end
      end
      sts_q.push_back(16'h0000);
      return sum;
   endfunction

   // monitor: scoreboard pop and compare
   always @(negedge clk) begin
      seg_t e;
      logic [15:0] es;
      if (rst_n) begin
         if (seg_valid && seg_ready) begin
            obs_sum = obs_sum + 64'(seg_len);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected segment addr", seg_addr, 64'h0);
            end else begin
               e = exp_q.pop_front();
               chk(seg_addr == e.a, "R2/R5/R6 segment addr", seg_addr, e.a);
               chk(seg_len == e.l, "R1/R2/R6 segment len", 64'(seg_len), 64'(e.l));
            end
         end
         if (done_valid) begin
            if (sts_q.size() == 0) begin
               chk(1'b0, "R9 unexpected completion", 64'(done_status), 64'h0);
            end else begin
               es = sts_q.pop_front();
               chk(done_status == es, "R9 completion status", 64'(done_status), 64'(es));
            end
         end
      end
   end

   // memory model: answers one cycle after accepting a request
   initial begin
      logic [63:0] a;
      forever begin
         @(negedge clk);
         if (rst_n && rd_valid) begin
            a = rd_addr;
            @(posedge clk);
            #1;
            rsp_data  = rd_mem(a);
            rsp_valid = 1'b1;
            @(posedge clk);
            #1;
            rsp_valid = 1'b0;
         end
      end
   end

   // segment back-pressure
   initial begin
      forever begin
         @(posedge clk);
         #1;
         seg_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired during %s", tag);
      finish_run();
   end

   task automatic run_case(input string name, input int mps, input logic [63:0] p1,
                           input logic [63:0] p2, input logic [31:0] len);
      logic [63:0] exp_sum;
      tag = name;
      exp_sum = model(mps, p1, p2, len);
      obs_sum = '0;
      @(posedge clk);
      #1;
      cfg_mps   = 4'(mps);
      cmd_ptr1  = p1;
      cmd_ptr2  = p2;
      cmd_len   = len;
      cmd_valid = 1'b1;
      @(posedge clk);
      #1;
      cmd_valid = 1'b0;
      @(negedge clk);
      chk(cmd_ready == 1'b0, "R11 busy after accept", 64'(cmd_ready), 64'h0);
      while (sts_q.size() != 0) @(negedge clk);
      @(negedge clk);
      chk(done_valid == 1'b0, "R9 completion is one cycle", 64'(done_valid), 64'h0);
      chk(exp_q.size() == 0, "R8/R10 missing segments", 64'(exp_q.size()), 64'h0);
      chk(obs_sum == exp_sum, "R10 byte total", obs_sum, exp_sum);
      chk(cmd_ready == 1'b1, "R11 idle after completion", 64'(cmd_ready), 64'h1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "reset cmd_ready", 64'(cmd_ready), 64'h1);
      chk(seg_valid == 1'b0, "reset seg_valid", 64'(seg_valid), 64'h0);
      chk(rd_valid == 1'b0, "reset rd_valid", 64'(rd_valid), 64'h0);
      chk(done_valid == 1'b0, "R9 reset done_valid", 64'(done_valid), 64'h0);

      // R2: fits inside the first page
      run_case("R2 single", 0, 64'h1000_0010, 64'h0, 32'd100);
      // R2 R5: unaligned first, direct second
      run_case("R5 direct", 0, 64'h2000_0F00, 64'h3000_0000, 32'h800);
      // R5: unaligned second pointer
      run_case("R5 misaligned", 0, 64'h2000_0F00, 64'h3000_0008, 32'h800);
      // R3: zero first pointer
      run_case("R3 null first", 0, 64'h0, 64'h3000_0000, 32'h800);
      // R4: zero second pointer with bytes left
      run_case("R4 null second", 0, 64'h1000, 64'h0, 32'h2000);
      // R5: remainder exactly one page
      run_case("R5 exact page", 0, 64'h5000, 64'h6000, 32'h2000);

      // R6: short table with partial tail
      put_list(64'h0050_0000, 0, 5, 64'h2000_0000, 64'h1000);
      bp_en = 1'b1;
      run_case("R6 table", 0, 64'h1000_0200, 64'h0050_0000, 32'h4F23);

      // R7: chained table pages
      put_list(64'h0060_0000, 0, 511, 64'h4000_0000, 64'h1000);
      mem[64'h0060_0000 + 64'(8 * 511)] = 64'h0070_0000;
      put_list(64'h0070_0000, 0, 9, 64'h5000_0000, 64'h1000);
      run_case("R7 chain", 0, 64'h7000_0000, 64'h0060_0000, 32'h1000 * 521);
      bp_en = 1'b0;

      // R1: larger page exponent, table path
      put_list(64'h0080_0000, 0, 3, 64'h9100_0000, 64'h2000);
      run_case("R1 mps1 table", 1, 64'h9000_0000, 64'h0080_0000, 32'h6005);
      // R1: larger page exponent, direct path
      run_case("R1 mps2 direct", 2, 64'hC000_3000, 64'hD000_4000, 32'h4FFF);

      // R8: zero entry after one good one
      mem[64'h0090_0000] = 64'h3300_0000;
      mem[64'h0090_0008] = 64'h0;
      run_case("R8 zero entry", 0, 64'h1000, 64'h0090_0000, 32'h4000);
      // R8: unaligned entry
      mem[64'h0098_0000] = 64'hA000_0004;
      run_case("R8 unaligned entry", 0, 64'h1000, 64'h0098_0000, 32'h3000);
      // R7 R8: unaligned chain entry
      put_list(64'h00A0_0000, 0, 511, 64'h6000_0000, 64'h1000);
      mem[64'h00A0_0000 + 64'(8 * 511)] = 64'h00B0_0010;
      run_case("R7 bad chain", 0, 64'h8000_0000, 64'h00A0_0000, 32'h1000 * 601);

      finish_run();
   end

endmodule